// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block sits between a column loader and the per-column converters of a display source driver. The loader fills a wide column code register with one 6-bit gray code per column. On the rising edge of the line strobe, the block copies the whole line into a holding latch and samples the polarity input. On the falling edge of the strobe, it moves the held line and a matching reference-bank select to its outputs in the same clock. The converters are enabled only while the strobe is low, so every column is released (high impedance) for the whole strobe-high interval.

Odd and even columns always receive reference banks of opposite polarity, and the polarity bit swaps them line by line. A width-select input disables a fixed middle band of columns when the narrower channel count is in use. The low-power flag passes through as the amplifier bias mode. All inputs are taken as synchronous to `clk`.

Top module: `line_latch_steer`

## Requirements
- R1: On the first clock where `strobe_i` is seen high after being low, the block captures `col_codes_i`. Changes to `col_codes_i` after that clock do not reach `code_o`. Column c (0-based) uses bits [6c+5:6c].
- R2: `code_o` and `bank_upper_o` keep their previous line for the whole strobe-high interval. They load the held line in the clock where `strobe_i` is first seen low again.
- R3: `drive_en_o` is all zero from the clock where the strobe rise is seen until the clock where the strobe fall is seen. After that clock the enables are asserted again.
- R4: `bank_upper_o[c]` = 1 selects the upper reference bank. With sampled polarity 0, columns with an even index c (output 1, 3, 5, ...) select the upper bank and odd-index columns select the lower bank. With polarity 1 the assignment is swapped.
- R5: Polarity is sampled at the strobe rise. A polarity change after the strobe fall leaves `bank_upper_o` unchanged until the next strobe.
- R6: A column's code and its bank select change in the same clock.
- R7: After reset, `code_o` is zero, `bank_upper_o` follows the polarity-0 pattern, and every enable stays zero until the first strobe completes.
- R8: With `full_width_i` = 0, the enables of columns 211 to 270 (1-based, indices 210 to 269) stay zero. All other columns behave normally.
- R9: `bias_normal_o` equals `lpc_n_i`, where 1 selects normal amplifier bias and 0 selects reduced bias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_codes_i | input | NCOL*CW | Column code register from the loader |
| strobe_i | input | 1 | Line strobe |
| pol_i | input | 1 | Polarity for the next line |
| full_width_i | input | 1 | 1 = all columns, 0 = middle band disabled |
| lpc_n_i | input | 1 | Low-power flag, active low |
| code_o | output | NCOL*CW | Latched per-column codes |
| bank_upper_o | output | NCOL | Per-column reference-bank select |
| drive_en_o | output | NCOL | Per-column output enable |
| bias_normal_o | output | 1 | Amplifier bias mode |

## Verification
The assertions assume that polarity does not move while the strobe is high, that each strobe lasts at least two clocks, and that a strobe never begins before the previous line is out. The stimulus changes `pol_i`, `full_width_i` and `lpc_n_i` only while the strobe is low. It holds every strobe high for exactly two clocks, then leaves several low clocks before the next one. While the strobe is high, the stimulus rewrites the column codes and, after the fall, flips polarity. This shows that neither change reaches the outputs.

// File: rtl/line_latch_steer.sv
module line_latch_steer #(
  parameter int NCOL   = 480,
  parameter int CW     = 6,
  parameter int GAP_LO = 211,
  parameter int GAP_HI = 270
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCOL*CW-1:0]   col_codes_i,
  input  logic                 strobe_i,
  input  logic                 pol_i,
  input  logic                 full_width_i,
  input  logic                 lpc_n_i,
  output logic [NCOL*CW-1:0]   code_o,
  output logic [NCOL-1:0]      bank_upper_o,
  output logic [NCOL-1:0]      drive_en_o,
  output logic                 bias_normal_o
);
  localparam int BUSW = NCOL * CW;

  logic              stb_q, armed_q, pol_hold_q;
  logic [BUSW-1:0]   hold_q, code_q;
  logic [NCOL-1:0]   bank_q, col_mask;

  wire stb_rise = strobe_i & ~stb_q;
  wire stb_fall = ~strobe_i & stb_q;

  function automatic logic [NCOL-1:0] bank_pattern(input logic pol);
    logic [NCOL-1:0] b;
    for (int c = 0; c < NCOL; c++) b[c] = ((c % 2) == 0) ^ pol;
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      armed_q    <= 1'b0;
      pol_hold_q <= 1'b0;
      hold_q     <= '0;
      code_q     <= '0;
      bank_q     <= bank_pattern(1'b0);
    end else begin
      stb_q <= strobe_i;
      if (stb_rise) begin
        hold_q     <= col_codes_i;
        pol_hold_q <= pol_i;
      end
      if (stb_fall) begin
        code_q  <= hold_q;
        bank_q  <= bank_pattern(pol_hold_q);
        armed_q <= 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_mask
    localparam bit IN_GAP = (c + 1 >= GAP_LO) && (c + 1 <= GAP_HI);
    if (IN_GAP) begin : g_gap
      assign col_mask[c] = full_width_i;
    end else begin : g_keep
      assign col_mask[c] = 1'b1;
    end
  end

  assign code_o        = code_q;
  assign bank_upper_o  = bank_q;
  assign drive_en_o    = (armed_q && !stb_q) ? col_mask : '0;
  assign bias_normal_o = lpc_n_i;

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> $stable(code_o));  // R2
  AST_HIZ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> (drive_en_o == '0));  // R3
  AST_HIZ_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && stb_q) |=> (drive_en_o == '0));  // R3
  AST_POL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && strobe_i) |-> $stable(pol_i));  // R5
  AST_BANK_WITH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_upper_o) |-> $past(stb_fall));  // R6
  AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_upper_o[0] != bank_upper_o[1]);  // R4
  AST_GAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !full_width_i |-> !drive_en_o[GAP_LO-1] && !drive_en_o[GAP_HI-1]);  // R8
endmodule

// File: tb/line_latch_steer_tb.sv
module line_latch_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 480;
  localparam int CW   = 6;
  localparam int BUSW = NCOL * CW;
  localparam int NVEC = 5;
  // {pol, full_width, lpc_n, seed[7:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 8'h03},
    {1'b1, 1'b1, 1'b0, 8'h2A},
    {1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 1'b0, 1'b0, 8'h3F},
    {1'b1, 1'b1, 1'b1, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [BUSW-1:0] col_codes = '0;
  logic strobe = 0, pol = 0, full_width = 1, lpc_n = 1;
  logic [BUSW-1:0] code_o;
  logic [NCOL-1:0] bank_o, en_o;
  logic bias_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_latch_steer u_dut (
    .clk(clk), .rst_n(rst_n), .col_codes_i(col_codes), .strobe_i(strobe),
    .pol_i(pol), .full_width_i(full_width), .lpc_n_i(lpc_n),
    .code_o(code_o), .bank_upper_o(bank_o), .drive_en_o(en_o), .bias_normal_o(bias_o)
  );

  function automatic logic [BUSW-1:0] line_of(input logic [7:0] seed);
    logic [BUSW-1:0] v;
    for (int c = 0; c < NCOL; c++) v[c*CW +: CW] = 6'((c * 7 + seed * 3 + (c >> 3)) & 63);
    return v;
  endfunction

  function automatic logic [NCOL-1:0] banks_of(input logic p);
    logic [NCOL-1:0] b;
    for (int c = 0; c < NCOL; c++) b[c] = ((c % 2) == 0) ? ~p : p;
    return b;
  endfunction

  function automatic logic [NCOL-1:0] mask_of(input logic full);
    logic [NCOL-1:0] m;
    for (int c = 0; c < NCOL; c++) m[c] = full || !(c >= 210 && c <= 269);
    return m;
  endfunction

  task automatic chk_codes(input logic [BUSW-1:0] act, exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      for (int c = 0; c < NCOL; c++)
        if (act[c*CW +: CW] !== exp[c*CW +: CW]) begin
          $display("FAIL %s col %0d code act=%h exp=%h", req, c, act[c*CW +: CW], exp[c*CW +: CW]);
          break;
        end
    end
  endtask

  task automatic chk_bits(input logic [NCOL-1:0] act, exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      for (int c = 0; c < NCOL; c++)
        if (act[c] !== exp[c]) begin
          $display("FAIL %s col %0d act=%b exp=%b", req, c, act[c], exp[c]);
          break;
        end
    end
  endtask

  task automatic chk1(input logic act, exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    logic [BUSW-1:0] prev_code;
    logic [NCOL-1:0] prev_bank;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_bits(en_o, '0, "R7 enables off after reset");
    chk_codes(code_o, '0, "R7 codes zero after reset");
    chk_bits(bank_o, banks_of(1'b0), "R7 reset bank pattern");
    col_codes = line_of(8'h5A);
    repeat (3) @(negedge clk);
    chk_bits(en_o, '0, "R7 enables off before first strobe");
    prev_code = '0;
    prev_bank = banks_of(1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] seed;
      logic p, f;
      {p, f, lpc_n, seed} = VEC[v];
      pol = p; full_width = f;
      col_codes = line_of(seed);
      @(negedge clk);
      chk1(bias_o, lpc_n, "R9 bias follows low-power flag");
      strobe = 1;
      @(negedge clk);
      chk_bits(en_o, '0, "R3 enables off at strobe rise");
      chk_codes(code_o, prev_code, "R2 codes held while strobe high");
      chk_bits(bank_o, prev_bank, "R6 bank held with code while strobe high");
      col_codes = line_of(seed ^ 8'h55);
      @(negedge clk);
      chk_bits(en_o, '0, "R3 enables off whole high interval");
      strobe = 0;
      @(negedge clk);
      chk_codes(code_o, line_of(seed), "R1 codes captured at rise");
      chk_bits(bank_o, banks_of(p), "R4 bank steering by polarity");
      chk_bits(en_o, mask_of(f), "R8 enables after fall per width mode");
      prev_code = line_of(seed);
      prev_bank = banks_of(p);
      pol = ~p;
      repeat (2) @(negedge clk);
      chk_bits(bank_o, prev_bank, "R5 late polarity change ignored");
      chk_codes(code_o, prev_code, "R1 late code change ignored");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule